// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects a set of interrupt sources and routes each of them to one or more cores and one or more parent interrupt lines. Each source is first passed through a two-flop synchronizer. It is then qualified by its own trigger kind (level or edge) and its own polarity, and it is gated by a per-source enable. Enables are changed only through a write-1-to-set register and a write-1-to-clear register, so turning one source on or off never disturbs the others.

Every source owns a one-byte route entry. The low four bits pick the destination cores and the high four bits pick the parent lines. Each core reads a status word showing only the pending sources routed to it. The output is a flat vector holding one group of parent-line wires per core. Software programs the block through a plain register port that takes word and byte-lane writes. Read data appears one cycle after the request.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset, every register reads as zero and every bit of `irq_out` is 0.
- R2: A write to offset 0x28 turns on the enable of each source whose data bit is 1. A write to offset 0x2C turns it off. Data bits of 0 leave the enable unchanged. The enable mask reads back at offset 0x24.
- R3: The route byte of source i sits at byte offset i, which is word i/4 and lane i%4. Bits 3:0 select cores 0..3 and bits 7:4 select lines 0..3. A write changes only the lanes whose byte enable is 1, and the word reads back as written.
- R4: With edge bit 0, an enabled source is pending while its input equals its polarity bit: 1 means active-high and 0 means active-low. This becomes visible after the two synchronizer stages.
- R5: With edge bit 1, an enabled source captures a pending latch on a rising edge (polarity 1) or a falling edge (polarity 0). The latch holds until a 1 is written to that bit of a status register.
- R6: A disabled source never shows in any status view and never drives `irq_out`. Edges that arrive while it is disabled are not captured.
- R7: The status word for core c is at offset 0x40+4c. It shows the pending sources whose route bit c is 1.
- R8: `irq_out[c*4+p]` is 1 exactly when some pending source has route bit c and route bit 4+p set.
- R9: The polarity register (offset 0x30) and the edge register (offset 0x34) take byte-lane writes and read back. Unmapped offsets read zero. Read data appears on the clock edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt source inputs |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CORE*NUM_LINE | Parent-line outputs, index core*NUM_LINE+line |

## Verification
The assertions assume that each bus request lasts one cycle and is either a read or a write, never both. They also assume that an enable write carries whole-word byte enables when the set and clear checks apply. The bench drives every access for exactly one cycle with all four lanes enabled, except for the deliberate lane tests on the route words and the polarity register. Source inputs change only at the falling edge. They are then held for three cycles, which lets the synchronizer settle and lets any edge be captured before the status views are read.

// File: rtl/lic_pkg.sv
package lic_pkg;

   localparam int OFS_EN_VIEW = 'h24;
   localparam int OFS_EN_SET  = 'h28;
   localparam int OFS_EN_CLR  = 'h2C;
   localparam int OFS_POL     = 'h30;
   localparam int OFS_EDGE    = 'h34;
   localparam int OFS_STAT    = 'h40;

   localparam int BUS_W   = 32;
   localparam int LANES   = 4;
   localparam int LANE_W  = 8;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

   function automatic logic [BUS_W-1:0] lane_mask(input logic [LANES-1:0] be);
      logic [BUS_W-1:0] m;
      for (int l = 0; l < LANES; l++) m[LANE_W*l +: LANE_W] = {LANE_W{be[l]}};
      return m;
   endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lic_src_cell.sv
module lic_src_cell
   import lic_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  s_in,
   input  logic  en,
   input  logic  pol,
   input  trig_e mode,
   input  logic  clr,
   output logic  pend
);
   logic prev_q;
   logic lat_q;
   logic edge_hit;
   logic level_act;

   assign level_act = pol ? s_in : ~s_in;
   assign edge_hit  = pol ? (s_in & ~prev_q) : (~s_in & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         lat_q  <= 1'b0;
      end else begin
         prev_q <= s_in;
         if (en && mode == TRIG_EDGE && edge_hit) lat_q <= 1'b1;
         else if (clr)                            lat_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (mode)
         TRIG_EDGE:  pend = en & lat_q;
         default:    pend = en & level_act;
      endcase
   end
endmodule

// File: rtl/lic_route.sv
module lic_route #(
   parameter int NUM_SRC  = 32,
   parameter int NUM_CORE = 4,
   parameter int NUM_LINE = 4,
   localparam int ROUTE_W = NUM_CORE + NUM_LINE
) (
   input  logic [ROUTE_W-1:0]       route [NUM_SRC],
   input  logic [NUM_SRC-1:0]       pend,
   output logic [NUM_SRC-1:0]       core_view [NUM_CORE],
   output logic [NUM_CORE*NUM_LINE-1:0] irq_out
);
   logic [NUM_SRC-1:0] line_sel [NUM_LINE];

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign core_view[c][i] = pend[i] & route[i][c];
      end
   end

   for (genvar p = 0; p < NUM_LINE; p++) begin : g_line
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign line_sel[p][i] = route[i][NUM_CORE+p];
      end
   end

   for (genvar c = 0; c < NUM_CORE; c++) begin : g_out_c
      for (genvar p = 0; p < NUM_LINE; p++) begin : g_out_p
         assign irq_out[c*NUM_LINE+p] = |(core_view[c] & line_sel[p]);
      end
   end
endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
   import lic_pkg::*;
#(
   parameter int NUM_SRC     = 32,
   parameter int NUM_CORE    = 4,
   parameter int NUM_LINE    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SRC-1:0]            src_in,
   input  logic                          bus_en,
   input  logic                          bus_we,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [3:0]                    bus_be,
   input  logic [31:0]                   bus_wdata,
   output logic [31:0]                   bus_rdata,
   output logic [NUM_CORE*NUM_LINE-1:0]  irq_out
);
   localparam int ROUTE_W     = NUM_CORE + NUM_LINE;
   localparam int ROUTE_WORDS = (NUM_SRC + LANES - 1) / LANES;
   localparam int WA_W        = ADDR_W - 2;

   initial begin
      assert (NUM_SRC > 0 && NUM_SRC <= BUS_W) else $fatal(1, "NUM_SRC out of range");
      assert (ROUTE_W <= LANE_W) else $fatal(1, "route entry wider than a byte");
      assert (SYNC_STAGES >= 2) else $fatal(1, "need at least two sync stages");
      assert (NUM_SRC <= OFS_EN_VIEW) else $fatal(1, "route bytes overlap registers");
      assert (OFS_STAT + 4*NUM_CORE <= (1 << ADDR_W)) else $fatal(1, "ADDR_W too small");
   end

   logic                wr;
   logic [BUS_W-1:0]    wbits;
   logic [BUS_W-1:0]    bmask;
   logic [NUM_SRC-1:0]  wsrc;
   logic [NUM_SRC-1:0]  bsrc;
   logic                hit_set, hit_clr, hit_pol, hit_edge, hit_stat;

   logic [ROUTE_W-1:0]  route_q [NUM_SRC];
   logic [NUM_SRC-1:0]  en_q, pol_q, edg_q;
   logic [NUM_SRC-1:0]  s_sync;
   logic [NUM_SRC-1:0]  pend;
   logic [NUM_SRC-1:0]  stat_clr;
   logic [NUM_SRC-1:0]  core_view [NUM_CORE];
   logic [BUS_W-1:0]    rd_next;
   logic [BUS_W-1:0]    rdata_q;

   assign wr     = bus_en & bus_we;
   assign bmask  = lane_mask(bus_be);
   assign wbits  = bus_wdata & bmask;
   assign wsrc   = wbits[NUM_SRC-1:0];
   assign bsrc   = bmask[NUM_SRC-1:0];

   assign hit_set  = wr && (bus_addr == ADDR_W'(OFS_EN_SET));
   assign hit_clr  = wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
   assign hit_pol  = wr && (bus_addr == ADDR_W'(OFS_POL));
   assign hit_edge = wr && (bus_addr == ADDR_W'(OFS_EDGE));
   assign hit_stat = wr && (bus_addr >= ADDR_W'(OFS_STAT))
                        && (bus_addr <  ADDR_W'(OFS_STAT + 4*NUM_CORE));
   assign stat_clr = hit_stat ? wsrc : '0;

   // per-source route bytes, lane i%4 of word i/4
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
      localparam int LANE = i % LANES;
      localparam int WORD = i / LANES;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) route_q[i] <= '0;
         else if (wr && bus_addr[ADDR_W-1:2] == WA_W'(WORD) && bus_be[LANE])
            route_q[i] <= bus_wdata[LANE_W*LANE +: ROUTE_W];
      end
   end

   // enable, polarity and trigger-kind registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pol_q <= '0;
         edg_q <= '0;
      end else begin
         if (hit_set)  en_q  <= en_q | wsrc;
         if (hit_clr)  en_q  <= en_q & ~wsrc;
         if (hit_pol)  pol_q <= (pol_q & ~bsrc) | wsrc;
         if (hit_edge) edg_q <= (edg_q & ~bsrc) | wsrc;
      end
   end

   lic_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (src_in),
      .q     (s_sync)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      lic_src_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .s_in  (s_sync[i]),
         .en    (en_q[i]),
         .pol   (pol_q[i]),
         .mode  (trig_e'(edg_q[i])),
         .clr   (stat_clr[i]),
         .pend  (pend[i])
      );
   end

   lic_route #(
      .NUM_SRC  (NUM_SRC),
      .NUM_CORE (NUM_CORE),
      .NUM_LINE (NUM_LINE)
   ) u_route (
      .route     (route_q),
      .pend      (pend),
      .core_view (core_view),
      .irq_out   (irq_out)
   );

   // read mux
   always_comb begin
      rd_next = '0;
      for (int w = 0; w < ROUTE_WORDS; w++) begin
         if (bus_addr[ADDR_W-1:2] == WA_W'(w)) begin
            for (int l = 0; l < LANES; l++) begin
               if (w*LANES + l < NUM_SRC)
                  rd_next[LANE_W*l +: LANE_W] = LANE_W'(route_q[w*LANES + l]);
            end
         end
      end
      if (bus_addr == ADDR_W'(OFS_EN_VIEW)) rd_next = BUS_W'(en_q);
      if (bus_addr == ADDR_W'(OFS_POL))     rd_next = BUS_W'(pol_q);
      if (bus_addr == ADDR_W'(OFS_EDGE))    rd_next = BUS_W'(edg_q);
      for (int c = 0; c < NUM_CORE; c++) begin
         if (bus_addr == ADDR_W'(OFS_STAT + 4*c)) rd_next = BUS_W'(core_view[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rdata_q <= '0;
      else if (bus_en && !bus_we) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;
endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 8,
   parameter int NOUT    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_en,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [3:0]         bus_be,
   input logic [31:0]        bus_wdata,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] pend,
   input logic [NOUT-1:0]    irq_out
);
   logic wr_set, wr_clr, any_set, any_clr;
   assign any_set = bus_en && bus_we && bus_addr == ADDR_W'('h28);
   assign any_clr = bus_en && bus_we && bus_addr == ADDR_W'('h2C);
   assign wr_set  = any_set && bus_be == 4'hF;
   assign wr_clr  = any_clr && bus_be == 4'hF;

   AST_SET_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]))); // R2

   AST_CLR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R2

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(any_set || any_clr) |=> $stable(en_q)); // R2

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~en_q) == '0)); // R6

   AST_OUT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> (|pend)); // R8
endmodule

bind routed_irq_ctrl lic_checker #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W),
   .NOUT    (NUM_CORE*NUM_LINE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .en_q      (en_q),
   .pend      (pend),
   .irq_out   (irq_out)
);

// File: tb/routed_irq_ctrl_bench.sv
module routed_irq_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] irq_out;

   int checks = 0;
   int errors = 0;

   logic [7:0]  m_route [32];
   logic [31:0] m_en = '0, m_pol = '0, m_edge = '0, m_lat = '0, m_in = '0;

   routed_irq_ctrl u_routed_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic bw(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
   endtask

   task automatic br(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_pend();
      logic [31:0] p;
      for (int i = 0; i < 32; i++)
         p[i] = m_edge[i] ? m_lat[i] : (m_pol[i] ? m_in[i] : ~m_in[i]);
      return p & m_en;
   endfunction

   function automatic logic [31:0] route_bits(input int b);
      logic [31:0] m;
      for (int i = 0; i < 32; i++) m[i] = m_route[i][b];
      return m;
   endfunction

   task automatic drive_in(input logic [31:0] v);
      logic [31:0] rise, fall;
      rise = v & ~m_in;
      fall = ~v & m_in;
      m_lat = m_lat | (((rise & m_pol) | (fall & ~m_pol)) & m_en & m_edge);
      m_in = v;
      @(negedge clk);
      src_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d, p;
      logic [15:0] eo;
      p = exp_pend();
      for (int c = 0; c < 4; c++) begin
         br(8'h40 + 8'(4*c), d);
         chk($sformatf("R7 core%0d view %s", c, tag), d, p & route_bits(c));
      end
      for (int c = 0; c < 4; c++)
         for (int q = 0; q < 4; q++)
            eo[c*4+q] = |(p & route_bits(c) & route_bits(4+q));
      chk($sformatf("R8 irq_out %s", tag), 32'(irq_out), 32'(eo));
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 32; i++) m_route[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      br(8'h24, d); chk("R1 enable view", d, 0);
      br(8'h30, d); chk("R1 polarity", d, 0);
      br(8'h34, d); chk("R1 edge", d, 0);
      br(8'h00, d); chk("R1 route word0", d, 0);
      br(8'h40, d); chk("R1 status", d, 0);
      chk("R1 irq_out", 32'(irq_out), 0);

      // R9: unmapped read, byte-lane polarity write
      br(8'h3C, d); chk("R9 unmapped", d, 0);
      bw(8'h30, 4'b0001, 32'hFFFF_FFFF);
      br(8'h30, d); chk("R9 pol lane0", d, 32'h0000_00FF);
      bw(8'h34, 4'b0100, 32'h00A5_0000);
      br(8'h34, d); chk("R9 edge lane2", d, 32'h00A5_0000);
      bw(8'h34, 4'hF, 32'h0);
      bw(8'h30, 4'hF, 32'h0);

      // R3: route bytes via single-lane writes
      for (int i = 0; i < 32; i++) begin
         logic [7:0] r;
         r = (i % 8 == 7) ? 8'hFF : 8'((1 << (i % 4)) | (1 << (4 + (i / 4) % 4)));
         m_route[i] = r;
         bw(8'(i & ~3), 4'(1 << (i % 4)), {4{r}});
      end
      for (int w = 0; w < 8; w++) begin
         br(8'(4*w), d);
         chk($sformatf("R3 route word %0d", w), d,
             {m_route[4*w+3], m_route[4*w+2], m_route[4*w+1], m_route[4*w]});
      end
      bw(8'h04, 4'b0010, 32'hA5A5_A5A5);
      br(8'h04, d);
      chk("R3 lane1 only", d, {m_route[7], m_route[6], 8'hA5, m_route[4]});
      bw(8'h04, 4'b0010, {4{m_route[5]}});

      // R2: enable set/clear
      bw(8'h28, 4'hF, 32'h0000_FFFF); m_en = 32'h0000_FFFF;
      br(8'h24, d); chk("R2 set", d, m_en);
      bw(8'h28, 4'hF, 32'hF000_0000); m_en |= 32'hF000_0000;
      br(8'h24, d); chk("R2 set keeps others", d, m_en);
      bw(8'h2C, 4'hF, 32'h0000_000F); m_en &= ~32'h0000_000F;
      br(8'h24, d); chk("R2 clear", d, m_en);
      bw(8'h28, 4'hF, 32'h0); bw(8'h2C, 4'hF, 32'h0);
      br(8'h24, d); chk("R2 zero bits no effect", d, m_en);

      // R4: level sweep active-high
      bw(8'h30, 4'hF, 32'hFFFF_FFFF); m_pol = '1;
      bw(8'h28, 4'hF, 32'hFFFF_FFFF); m_en = '1;
      for (int k = 0; k < 32; k++) begin
         drive_in(32'(1) << k);
         check_all($sformatf("R4 walk %0d", k));
      end
      // R4: active-low
      bw(8'h30, 4'hF, 32'h0); m_pol = '0;
      drive_in(32'hFFFF_0000); check_all("R4 low A");
      drive_in(32'h1234_5678); check_all("R4 low B");

      // R6: masked level sources
      bw(8'h30, 4'hF, 32'hFFFF_FFFF); m_pol = '1;
      bw(8'h2C, 4'hF, 32'hF0F0_F0F0); m_en = 32'h0F0F_0F0F;
      drive_in(32'hFFFF_FFFF); check_all("R6 masked level");

      // R5: edge mode
      bw(8'h28, 4'hF, 32'hFFFF_FFFF); m_en = '1;
      bw(8'h30, 4'hF, 32'h5555_5555); m_pol = 32'h5555_5555;
      drive_in(32'h0);
      bw(8'h34, 4'hF, 32'hFFFF_FFFF); m_edge = '1;
      bw(8'h40, 4'hF, 32'hFFFF_FFFF); m_lat = '0;
      check_all("R5 cleared");
      drive_in(32'hFFFF_FFFF); check_all("R5 rising");
      drive_in(32'h0);         check_all("R5 falling");
      bw(8'h44, 4'hF, 32'h0000_FFFF); m_lat &= ~32'h0000_FFFF;
      check_all("R5 w1c");

      // R6: edges while disabled are dropped
      bw(8'h40, 4'hF, 32'hFFFF_FFFF); m_lat = '0;
      bw(8'h2C, 4'hF, 32'hFF00_0000); m_en = 32'h00FF_FFFF;
      drive_in(32'hFFFF_FFFF);
      drive_in(32'h0);
      bw(8'h28, 4'hF, 32'hFF00_0000); m_en = '1;
      check_all("R6 edges ignored when disabled");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule